// File: doc/BRIEF.md
# Multi-Lane SPI Flash Byte Reader

This block fetches single bytes from a serial NOR flash under host control, one byte per command. A host programs a lane configuration, a timing option, one of two read opcodes and a start address through a byte-wide register port. Writing the fetch code then runs one complete flash transaction: chip select low, opcode and address shifted out on one lane, optional dummy clocks, then a data phase on one, two or four lanes. The byte received lands in a read-data register, the internal address steps forward by one and the busy indication clears by itself.

Software streams a region by repeating the fetch command and reading the data register each time. The flash side uses chip select, a mode-0 serial clock (idle low, sampled on the rising edge) and four data lines, each split into output, output-enable and input.

Top module: `spi_rd_byte_reader`

## Requirements
- R1: After reset every register reads 0x00, chip select is high, the serial clock is low and no data line is driven.
- R2: Register indices: 0 control, 1 lane configuration, 2 timing, 3 single/dual opcode, 4 quad opcode, 5..8 address bytes 0..3 (byte 0 least significant), 9 read data. The lane configuration keeps only bits 0, 1, 2 and 4 (mask 0x17), timing keeps only bit 0, the read-data register ignores host writes, and unmapped indices read 0x00.
- R3: Writing 0x81 to the control register while idle starts exactly one byte fetch; the control register reads 0x81 while the fetch runs and 0x00 once it clears by itself. Any other value written to it starts nothing.
- R4: Opcode then address are sent MSB first on data line 0, changing after falling and stable at rising clock edges; the address is 24 bits when lane configuration bit 4 is 0 and 32 bits when it is 1.
- R5: Lane configuration bit 2 selects four-lane data and wins over bit 0, which selects two-lane data; with both clear the data phase uses one lane. Bit 1 is stored but changes nothing on the wire. Four-lane fetches send the opcode from index 4, all others from index 3.
- R6: Exactly 8 dummy clocks follow the address when timing bit 0 is 1 or the data phase uses two or four lanes; a one-lane fetch with timing bit 0 clear has none.
- R7: Data is received MSB first: one lane on line 1, two lanes with line 1 carrying the higher bit of each pair, four lanes with line 3 carrying the highest. Only line 0 is ever driven, and only during opcode and address.
- R8: With N serial clocks per fetch and HALF system cycles per clock half period, the control register reads 0x81 for exactly 2*HALF*N+1 cycles.
- R9: After each fetch the address registers advance by one; in 24-bit mode the low three bytes wrap together and byte 3 keeps its value, in 32-bit mode all four bytes count.
- R10: Host writes to any register while a fetch runs have no effect, including a second fetch code.
- R11: Whenever no fetch is running chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_idx | input | IDX_W | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the register at host_idx |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_io_o | output | 4 | Data line output values |
| flash_io_oe | output | 4 | Data line output enables |
| flash_io_i | input | 4 | Data line input values |

## Verification
A host write takes effect at the next clock edge, and host_rdata follows host_idx combinationally, so the bench drives on falling clock edges and reads one nanosecond later. A fetch raises the control register on the edge that accepts the fetch code and drops it 2*HALF*N+1 cycles later, after which the data byte and the stepped address are already visible; the bench polls the control register once per cycle, counts those cycles and only then reads the results. A flash model in the bench captures opcode and address on rising serial clocks and presents each data chunk after the falling clock that ends the previous phase, so every sampled value has been stable for HALF cycles.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SEND  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 4;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int TX_W       = BYTE_W + ADDR_W;
  localparam int CMD3_BITS  = BYTE_W + 24;
  localparam int CMD4_BITS  = BYTE_W + 32;

  localparam logic [7:0] FETCH_CODE  = 8'h81;
  localparam logic [7:0] LANE_MASK   = 8'h17;
  localparam logic [7:0] TIMING_MASK = 8'h01;

  localparam int BIT_DUAL  = 0;
  localparam int BIT_QUAD  = 2;
  localparam int BIT_ADR4  = 4;
  localparam int BIT_FAST  = 0;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_LANE   = 1;
  localparam int IDX_TIMING = 2;
  localparam int IDX_OPC1   = 3;
  localparam int IDX_OPC4   = 4;
  localparam int IDX_ADDR   = 5;
  localparam int IDX_RDATA  = 9;

  function automatic lane_e lane_pick(input logic [7:0] cfg);
    if (cfg[BIT_QUAD])      return LANE_X4;
    else if (cfg[BIT_DUAL]) return LANE_X2;
    else                    return LANE_X1;
  endfunction

  // number of serial clocks in the data phase, minus one
  function automatic logic [2:0] data_last(input lane_e l);
    case (l)
      LANE_X4: return 3'd1;
      LANE_X2: return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_en = clr_i || run_i;

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rd_regs.sv
module spi_rd_regs
  import spi_rd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              done_i,
  input  logic [7:0]        byte_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [7:0]        opcode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr4_o,
  output lane_e             lanes_o,
  output logic              dummy_o
);
  logic              busy_q, busy_d;
  logic [7:0]        lane_q, lane_d;
  logic [7:0]        tim_q, tim_d;
  logic [7:0]        opc1_q, opc1_d;
  logic [7:0]        opc4_q, opc4_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [7:0]        rdat_q, rdat_d;
  logic              wr_ok;
  logic [ADDR_W-1:0] adr_inc;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input int n);
    return idx == IDX_W'(n);
  endfunction

  assign wr_ok   = host_we && !busy_q;
  assign start_o = wr_ok && hit(host_idx, IDX_CTRL) && (host_wdata == FETCH_CODE);

  assign adr_inc = lane_q[BIT_ADR4] ? (adr_q + ADDR_W'(1))
                                    : {adr_q[ADDR_W-1:24], adr_q[23:0] + 24'd1};

  always_comb begin
    busy_d = busy_q;
    lane_d = lane_q;
    tim_d  = tim_q;
    opc1_d = opc1_q;
    opc4_d = opc4_q;
    adr_d  = adr_q;
    rdat_d = rdat_q;
    if (start_o)     busy_d = 1'b1;
    else if (done_i) busy_d = 1'b0;
    if (wr_ok) begin
      if (hit(host_idx, IDX_LANE))   lane_d = host_wdata & LANE_MASK;
      if (hit(host_idx, IDX_TIMING)) tim_d  = host_wdata & TIMING_MASK;
      if (hit(host_idx, IDX_OPC1))   opc1_d = host_wdata;
      if (hit(host_idx, IDX_OPC4))   opc4_d = host_wdata;
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (hit(host_idx, IDX_ADDR + b)) adr_d[b*8 +: 8] = host_wdata;
      end
    end
    if (done_i) begin
      adr_d  = adr_inc;
      rdat_d = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lane_q <= '0;
      tim_q  <= '0;
      opc1_q <= '0;
      opc4_q <= '0;
      adr_q  <= '0;
      rdat_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (wr_ok) begin
        lane_q <= lane_d;
        tim_q  <= tim_d;
        opc1_q <= opc1_d;
        opc4_q <= opc4_d;
      end
      if (wr_ok || done_i) adr_q  <= adr_d;
      if (done_i)          rdat_q <= rdat_d;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (hit(host_idx, IDX_CTRL))   host_rdata = busy_q ? FETCH_CODE : 8'h00;
    if (hit(host_idx, IDX_LANE))   host_rdata = lane_q;
    if (hit(host_idx, IDX_TIMING)) host_rdata = tim_q;
    if (hit(host_idx, IDX_OPC1))   host_rdata = opc1_q;
    if (hit(host_idx, IDX_OPC4))   host_rdata = opc4_q;
    if (hit(host_idx, IDX_RDATA))  host_rdata = rdat_q;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (hit(host_idx, IDX_ADDR + b)) host_rdata = adr_q[b*8 +: 8];
    end
  end

  assign busy_o   = busy_q;
  assign lanes_o  = lane_pick(lane_q);
  assign opcode_o = (lanes_o == LANE_X4) ? opc4_q : opc1_q;
  assign addr_o   = adr_q;
  assign addr4_o  = lane_q[BIT_ADR4];
  assign dummy_o  = tim_q[BIT_FAST] || (lanes_o != LANE_X1);
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
  import spi_rd_pkg::*;
#(
  parameter int HALF       = 2,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr4_i,
  input  lane_e             lanes_i,
  input  logic              dummy_i,
  input  logic [3:0]        io_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe,
  output logic              done_o,
  output logic [7:0]        byte_o
);
  localparam int CNT_W = $clog2(CMD4_BITS + DUMMY_CLKS + 1);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [7:0]        rx_q, rx_d, rx_nx;
  logic              sck_q, sck_d;
  logic              run, tick, rise, fall;
  logic [CNT_W-1:0]  data_cnt;

  assign run  = (ph_q == PH_SEND) || (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign rise = tick && !sck_q;
  assign fall = tick && sck_q;
  assign data_cnt = CNT_W'(data_last(lanes_i));

  spi_rd_tick #(.HALF(HALF)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .clr_i  (start_i),
    .tick_o (tick)
  );

  always_comb begin
    case (lanes_i)
      LANE_X4: rx_nx = {rx_q[3:0], io_i[3:0]};
      LANE_X2: rx_nx = {rx_q[5:0], io_i[1:0]};
      default: rx_nx = {rx_q[6:0], io_i[1]};
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    sck_d = sck_q;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = PH_SEND;
          sck_d = 1'b0;
          if (addr4_i) begin
            cnt_d = CNT_W'(CMD4_BITS - 1);
            tx_d  = {opcode_i, addr_i};
          end else begin
            cnt_d = CNT_W'(CMD3_BITS - 1);
            tx_d  = {opcode_i, addr_i[23:0], 8'h00};
          end
        end
      end
      PH_SEND, PH_DUMMY, PH_DATA: begin
        if (rise) begin
          sck_d = 1'b1;
          if (ph_q == PH_DATA) rx_d = rx_nx;
        end
        if (fall) begin
          sck_d = 1'b0;
          if (cnt_q == '0) begin
            if (ph_q == PH_SEND && dummy_i) begin
              ph_d  = PH_DUMMY;
              cnt_d = CNT_W'(DUMMY_CLKS - 1);
            end else if (ph_q != PH_DATA) begin
              ph_d  = PH_DATA;
              cnt_d = data_cnt;
            end else begin
              ph_d  = PH_DONE;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
            if (ph_q == PH_SEND) tx_d = {tx_q[TX_W-2:0], 1'b0};
          end
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      sck_q <= sck_d;
      if (start_i || fall) begin
        cnt_q <= cnt_d;
        tx_q  <= tx_d;
      end
      if (rise) rx_q <= rx_d;
    end
  end

  assign cs_n_o = (ph_q == PH_IDLE) || (ph_q == PH_DONE);
  assign sck_o  = sck_q;
  assign io_oe  = (ph_q == PH_SEND) ? 4'b0001 : 4'b0000;
  assign io_o   = (ph_q == PH_SEND) ? {3'b000, tx_q[TX_W-1]} : 4'b0000;
  assign done_o = (ph_q == PH_DONE);
  assign byte_o = rx_q;
endmodule

// File: rtl/spi_rd_byte_reader.sv
module spi_rd_byte_reader
  import spi_rd_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int HALF       = 2,
  parameter int DUMMY_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             flash_cs_n,
  output logic             flash_sck,
  output logic [3:0]       flash_io_o,
  output logic [3:0]       flash_io_oe,
  input  logic [3:0]       flash_io_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_in_n;
  logic              start_w, busy_w, done_w, addr4_w, dummy_w;
  logic [7:0]        opc_w, byte_w;
  logic [ADDR_W-1:0] addr_w;
  lane_e             lanes_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  spi_rd_regs #(.IDX_W(IDX_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .host_we    (host_we),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .done_i     (done_w),
    .byte_i     (byte_w),
    .start_o    (start_w),
    .busy_o     (busy_w),
    .opcode_o   (opc_w),
    .addr_o     (addr_w),
    .addr4_o    (addr4_w),
    .lanes_o    (lanes_w),
    .dummy_o    (dummy_w)
  );

  spi_rd_engine #(.HALF(HALF), .DUMMY_CLKS(DUMMY_CLKS)) eng_i (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .start_i  (start_w),
    .opcode_i (opc_w),
    .addr_i   (addr_w),
    .addr4_i  (addr4_w),
    .lanes_i  (lanes_w),
    .dummy_i  (dummy_w),
    .io_i     (flash_io_i),
    .cs_n_o   (flash_cs_n),
    .sck_o    (flash_sck),
    .io_o     (flash_io_o),
    .io_oe    (flash_io_oe),
    .done_o   (done_w),
    .byte_o   (byte_w)
  );
endmodule

// File: rtl/spi_rd_byte_reader_chk.sv
module spi_rd_byte_reader_chk
  import spi_rd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_oe,
  input logic [7:0] opcode,
  input logic       addr4,
  input lane_e      lanes
);
  // R11
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R11
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R7
  only_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe & 4'b1110) == 4'b0000);

  // R7
  no_drive_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  // R3
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(opcode) && $stable(addr4) && $stable(lanes)));
endmodule

bind spi_rd_byte_reader spi_rd_byte_reader_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_in_n),
  .busy   (busy_w),
  .done   (done_w),
  .cs_n   (flash_cs_n),
  .sck    (flash_sck),
  .io_oe  (flash_io_oe),
  .opcode (opc_w),
  .addr4  (addr4_w),
  .lanes  (lanes_w)
);

// File: tb/spi_rd_byte_reader_tb_top.sv
`timescale 1ns/1ps
module spi_rd_byte_reader_tb_top;
  localparam int HALF = 2;

  logic       clk;
  logic       rst_n;
  logic       host_we;
  logic [3:0] host_idx;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       cs_n, sck;
  logic [3:0] io_o, io_oe, io_i;

  int checks = 0;
  int errors = 0;

  spi_rd_byte_reader #(.IDX_W(4), .HALF(HALF), .DUMMY_CLKS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flash_cs_n(cs_n), .flash_sck(sck), .flash_io_o(io_o),
    .flash_io_oe(io_oe), .flash_io_i(io_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- flash model ----------------
  int          m_cmd_bits = 32;
  int          m_pre      = 32;
  int          m_lanes    = 1;
  logic [39:0] cap_sr;
  logic [7:0]  cap_opc;
  logic [31:0] cap_addr;
  logic [7:0]  m_byte;
  int          rise_cnt;
  bit          oe_bad;

  function automatic logic [7:0] flash_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  always @(negedge cs_n) begin
    rise_cnt = 0;
    oe_bad   = 1'b0;
    io_i     = 4'h0;
  end

  always @(posedge sck) begin
    if (rise_cnt < m_cmd_bits) begin
      cap_sr = {cap_sr[38:0], io_o[0]};
      if (io_oe != 4'b0001) oe_bad = 1'b1;
    end else if (io_oe != 4'b0000) oe_bad = 1'b1;
    rise_cnt++;
    if (rise_cnt == m_cmd_bits) begin
      if (m_cmd_bits == 40) begin
        cap_opc = cap_sr[39:32]; cap_addr = cap_sr[31:0];
      end else begin
        cap_opc = cap_sr[31:24]; cap_addr = {8'h00, cap_sr[23:0]};
      end
      m_byte = flash_byte(cap_addr);
    end
  end

  always @(negedge sck) begin
    if (rise_cnt >= m_pre && rise_cnt < m_pre + 8 / m_lanes) begin
      automatic int j = rise_cnt - m_pre;
      case (m_lanes)
        4:       io_i = (j == 0) ? m_byte[7:4] : m_byte[3:0];
        2:       io_i = {2'b00, m_byte[7-2*j], m_byte[6-2*j]};
        default: io_i = {2'b00, m_byte[7-j], 1'b0};
      endcase
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = idx; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] idx, output logic [7:0] v);
    host_idx = idx;
    #1;
    v = host_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int b = 0; b < 4; b++) host_wr(4'(5 + b), a[b*8 +: 8]);
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      host_rd(4'(5 + b), v);
      a[b*8 +: 8] = v;
    end
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] v;
    cyc = 0;
    for (int k = 0; k < 4000; k++) begin
      host_rd(4'd0, v);
      if (v != 8'h81) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  // one fetch with all its result checks
  task automatic do_read(input logic [31:0] areg, input logic [7:0] opc_exp,
                         input int lanes, input bit a4, input bit dmy);
    int n, cyc;
    logic [31:0] sent, nxt, got;
    logic [7:0]  v;
    n = 8 + (a4 ? 32 : 24) + (dmy ? 8 : 0) + 8 / lanes;
    m_cmd_bits = a4 ? 40 : 32;
    m_pre      = m_cmd_bits + (dmy ? 8 : 0);
    m_lanes    = lanes;
    sent = a4 ? areg : {8'h00, areg[23:0]};
    nxt  = a4 ? areg + 1 : {areg[31:24], areg[23:0] + 24'd1};
    host_wr(4'd0, 8'h81);
    wait_idle(cyc);
    chk("R8 busy cycles", cyc, 2 * HALF * n + 1);
    chk("R3 control self-cleared", {24'd0, host_rdata}, 32'h0);
    chk("R5 opcode on wire", {24'd0, cap_opc}, {24'd0, opc_exp});
    chk("R4 address on wire", cap_addr, sent);
    chk("R6 serial clock count", rise_cnt, n);
    chk("R7 drive only line0 in command", {31'd0, oe_bad}, 0);
    host_rd(4'd9, v);
    chk("R7 received byte", {24'd0, v}, {24'd0, flash_byte(sent)});
    get_addr(got);
    chk("R9 address advanced", got, nxt);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [7:0] v;
    for (int i = 0; i < 10; i++) begin
      host_rd(4'(i), v);
      chk("R1 register reset value", {24'd0, v}, 0);
    end
    chk("R1 chip select idle", {31'd0, cs_n}, 1);
    chk("R11 clock idle", {31'd0, sck}, 0);
    chk("R1 no drive", {28'd0, io_oe}, 0);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    host_wr(4'd1, 8'hFF); host_rd(4'd1, v);
    chk("R2 lane mask", {24'd0, v}, 32'h17);
    host_wr(4'd2, 8'hFF); host_rd(4'd2, v);
    chk("R2 timing mask", {24'd0, v}, 32'h01);
    host_wr(4'd9, 8'h55); host_rd(4'd9, v);
    chk("R2 read data not writable", {24'd0, v}, 0);
    host_rd(4'd12, v);
    chk("R2 unmapped index", {24'd0, v}, 0);
    host_wr(4'd3, 8'hA7); host_rd(4'd3, v);
    chk("R2 opcode slot", {24'd0, v}, 32'hA7);
    host_wr(4'd1, 8'h00); host_wr(4'd2, 8'h00);
  endtask

  task automatic t_bad_code;
    logic [7:0] v;
    bit sel;
    sel = 1'b0;
    host_wr(4'd0, 8'h80);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!cs_n) sel = 1'b1;
    end
    host_rd(4'd0, v);
    chk("R3 other code starts nothing", {24'd0, v}, 0);
    chk("R11 stays deselected", {31'd0, sel}, 0);
  endtask

  task automatic t_single_slow;
    host_wr(4'd3, 8'h03);
    set_addr(32'h0012_3456);
    do_read(32'h0012_3456, 8'h03, 1, 1'b0, 1'b0);
  endtask

  task automatic t_single_fast;
    host_wr(4'd2, 8'h01);
    host_wr(4'd3, 8'h0B);
    set_addr(32'h00AB_CDFE);
    do_read(32'h00AB_CDFE, 8'h0B, 1, 1'b0, 1'b1);
    do_read(32'h00AB_CDFF, 8'h0B, 1, 1'b0, 1'b1);
    host_wr(4'd2, 8'h00);
  endtask

  task automatic t_dual;
    // bit 1 set as well: it must not alter the wire (R5)
    host_wr(4'd1, 8'h03);
    host_wr(4'd3, 8'h3B);
    set_addr(32'h0000_1F80);
    do_read(32'h0000_1F80, 8'h3B, 2, 1'b0, 1'b1);
  endtask

  task automatic t_quad_priority;
    host_wr(4'd1, 8'h05);
    host_wr(4'd4, 8'h6B);
    set_addr(32'h0055_AA01);
    do_read(32'h0055_AA01, 8'h6B, 4, 1'b0, 1'b1);
  endtask

  task automatic t_quad_4byte;
    host_wr(4'd1, 8'h14);
    host_wr(4'd4, 8'h6C);
    set_addr(32'h89AB_CDEF);
    do_read(32'h89AB_CDEF, 8'h6C, 4, 1'b1, 1'b1);
  endtask

  task automatic t_wrap_3byte;
    host_wr(4'd1, 8'h00);
    host_wr(4'd2, 8'h01);
    host_wr(4'd3, 8'h0B);
    set_addr(32'h7FFF_FFFF);
    do_read(32'h7FFF_FFFF, 8'h0B, 1, 1'b0, 1'b1);
    host_wr(4'd2, 8'h00);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    logic [7:0] v;
    bit sel;
    host_wr(4'd1, 8'h00);
    host_wr(4'd3, 8'h03);
    set_addr(32'h0000_4000);
    m_cmd_bits = 32; m_pre = 32; m_lanes = 1;
    host_wr(4'd0, 8'h81);
    host_wr(4'd1, 8'h04);
    host_wr(4'd3, 8'hEE);
    host_wr(4'd5, 8'h77);
    host_wr(4'd0, 8'h81);
    wait_idle(cyc);
    chk("R10 opcode kept during fetch", {24'd0, cap_opc}, 32'h03);
    chk("R10 data unaffected", {28'd0, m_lanes[3:0]}, 1);
    host_rd(4'd9, v);
    chk("R10 byte from original address", {24'd0, v}, {24'd0, flash_byte(32'h4000)});
    host_rd(4'd1, v);
    chk("R10 lane config unchanged", {24'd0, v}, 0);
    host_rd(4'd3, v);
    chk("R10 opcode unchanged", {24'd0, v}, 32'h03);
    host_rd(4'd5, v);
    chk("R10 address byte only stepped", {24'd0, v}, 32'h01);
    sel = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!cs_n) sel = 1'b1;
    end
    chk("R10 second fetch code ignored", {31'd0, sel}, 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_idx = 4'd0; host_wdata = 8'h00;
    io_i = 4'h0; cap_sr = '0; cap_opc = '0; cap_addr = '0; m_byte = '0;
    rise_cnt = 0; oe_bad = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_regmap();
    t_bad_code();
    t_single_slow();
    t_single_fast();
    t_dual();
    t_quad_priority();
    t_quad_4byte();
    t_wrap_3byte();
    t_busy_ignore();
    finish_run();
  end
endmodule